// File: doc/BRIEF.md
# CPU wait and timer unit

This unit serves the wait/timer instruction of a small CPU core. It holds two countdown channels. The blocking wait channel holds the core's issue stage stalled until its countdown runs out. The interrupting timer channel counts in the background while the core keeps running. When it expires, it raises an interrupt request that carries a stored interrupt number.

Each command carries a tick count, an interrupt number, a resolution and a cancel flag. The resolution is the number of clocks per tick. The interrupt-number field picks the channel: zero means the wait channel and any other value means the timer channel. With the cancel flag clear, the command loads the chosen channel with new values. With the cancel flag set, the chosen channel stops and no completion is reported. Each channel has its own prescaler and count, so a timer can expire while a wait is still running without disturbing it.

Top module: `cpu_wait_timer`

## Requirements
- R1: After reset, stall is 0, irq_req is 0 and irq_num is 0.
- R2: A command with cmd_cancel=0 and cmd_num=0 holds stall at 1 for exactly D cycles. Counting starts in the cycle after the command is sampled. D = cmd_ticks × N, where N = cmd_res when cmd_res is nonzero and N = 1 when cmd_res is 0.
- R3: A tick count of 0 means an expiry of D = 1. A wait then stalls for exactly one cycle, and a timer raises its request in the second cycle after the command.
- R4: A command with cmd_cancel=0 and cmd_num≠0 leaves stall at 0. irq_req rises D+1 cycles after the command is sampled, and irq_num then equals that command's cmd_num.
- R5: irq_req stays 1 until irq_ack is sampled at 1. In the cycle after that, irq_req is 0, unless the timer expired in the same cycle as the acknowledge.
- R6: A command with cmd_cancel=1 and cmd_num=0 ends a running wait, and stall is 0 from the next cycle on.
- R7: A command with cmd_cancel=1 and cmd_num≠0 stops a running timer, and no interrupt request follows.
- R8: A timer command issued while the timer is counting restarts it. The new count and new number take effect, and the old countdown never fires.
- R9: The channels are independent. A timer that expires during a wait still raises its request, and the wait still stalls for its full D. This also holds when both expire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_cancel | input | 1 | 1 = cancel the selected channel, 0 = start it |
| cmd_ticks | input | 32 | Tick count |
| cmd_num | input | 5 | Interrupt number; 0 selects the wait channel |
| cmd_res | input | 16 | Clocks per tick; 0 means 1 |
| irq_ack | input | 1 | Acknowledge of the pending request |
| stall | output | 1 | Holds instruction issue while a wait runs |
| irq_req | output | 1 | Pending timer interrupt request |
| irq_num | output | 5 | Number of the pending request |

## Verification
Two events can fall in the same cycle: the timer can expire in the very cycle that the wait's countdown ends, and an expiry can coincide with an acknowledge of a prior request. The bench provokes the first case by starting a timer with D+1 and then a wait with D one cycle later. It then checks that stall lasts exactly D cycles, that irq_req is absent during the wait, and that irq_req is present in the first cycle without stall. The bench also acknowledges a request in the middle of a wait and checks that the wait's length is unchanged. It checks every duration against the product of ticks and resolution, computed in bench functions.

// File: rtl/wt_pkg.sv
package wt_pkg;
    parameter int TICK_W = 32;
    parameter int RES_W  = 16;
    parameter int NUM_W  = 5;
    parameter int NCHAN  = 2;
    parameter int CH_WAIT  = 0;
    parameter int CH_TIMER = 1;

    typedef struct packed {
        logic              active;
        logic [TICK_W-1:0] ticks;
        logic [RES_W-1:0]  pre;
        logic [RES_W-1:0]  reload;
    } chan_t;

    typedef struct packed {
        logic             req;
        logic [NUM_W-1:0] num;
    } irq_t;
endpackage

// File: rtl/wt_channel.sv
module wt_channel
    import wt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cancel,
    input  logic [TICK_W-1:0] ticks_in,
    input  logic [RES_W-1:0]  res_in,
    output logic              active,
    output logic              done
);
    chan_t st_d, st_q;
    logic  last_tick;

    always_comb begin
        st_d      = st_q;
        last_tick = (st_q.ticks == TICK_W'(1)) && (st_q.pre == RES_W'(1));
        done      = st_q.active && ((st_q.ticks == '0) || last_tick);
        if (st_q.active) begin
            if (done) begin
                st_d.active = 1'b0;
            end else if (st_q.pre == RES_W'(1)) begin
                st_d.pre   = st_q.reload;
                st_d.ticks = st_q.ticks - TICK_W'(1);
            end else begin
                st_d.pre = st_q.pre - RES_W'(1);
            end
        end
        if (cancel) begin
            st_d.active = 1'b0;
        end
        if (start) begin
            st_d.active = 1'b1;
            st_d.ticks  = ticks_in;
            st_d.reload = (res_in == '0) ? RES_W'(1) : res_in;
            st_d.pre    = (res_in == '0) ? RES_W'(1) : res_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    // R2
    expire_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !active);
    // R2
    ticks_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && !start |=> st_q.ticks <= $past(st_q.ticks));
    // R6
    cancel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel && !start |=> !done);
endmodule

// File: rtl/wt_irq_hold.sv
module wt_irq_hold
    import wt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [NUM_W-1:0] num_in,
    input  logic             ack,
    output logic             req,
    output logic [NUM_W-1:0] num
);
    irq_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        if (ack) ir_d.req = 1'b0;
        if (fire) begin
            ir_d.req = 1'b1;
            ir_d.num = num_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign req = ir_q.req;
    assign num = ir_q.num;

    // R5
    req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack |=> req);
    // R4
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(fire));
    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !fire |=> !req);
endmodule

// File: rtl/cpu_wait_timer.sv
module cpu_wait_timer
    import wt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_cancel,
    input  logic [TICK_W-1:0] cmd_ticks,
    input  logic [NUM_W-1:0]  cmd_num,
    input  logic [RES_W-1:0]  cmd_res,
    input  logic              irq_ack,
    output logic              stall,
    output logic              irq_req,
    output logic [NUM_W-1:0]  irq_num
);
    logic             sel_timer;
    logic [NCHAN-1:0] ch_start, ch_cancel, ch_active, ch_done;
    logic [NUM_W-1:0] tnum_d, tnum_q;

    assign sel_timer = (cmd_num != '0);

    for (genvar gi = 0; gi < NCHAN; gi++) begin : g_chan
        localparam logic IS_TIMER = (gi == CH_TIMER);
        assign ch_start[gi]  = cmd_valid && !cmd_cancel && (sel_timer == IS_TIMER);
        assign ch_cancel[gi] = cmd_valid &&  cmd_cancel && (sel_timer == IS_TIMER);
        wt_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (ch_start[gi]),
            .cancel   (ch_cancel[gi]),
            .ticks_in (cmd_ticks),
            .res_in   (cmd_res),
            .active   (ch_active[gi]),
            .done     (ch_done[gi])
        );
    end

    always_comb begin
        tnum_d = tnum_q;
        if (ch_start[CH_TIMER]) tnum_d = cmd_num;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tnum_q <= '0;
        else        tnum_q <= tnum_d;
    end

    wt_irq_hold u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (ch_done[CH_TIMER]),
        .num_in (tnum_q),
        .ack    (irq_ack),
        .req    (irq_req),
        .num    (irq_num)
    );

    assign stall = ch_active[CH_WAIT];

    // R4
    timer_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall && !ch_start[CH_WAIT] |=> !stall);
    // R9
    wait_survives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall && !ch_done[CH_WAIT] && !cmd_valid |=> stall);
endmodule

// File: tb/tb_cpu_wait_timer.sv
module tb_cpu_wait_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_cancel = 1'b0, irq_ack = 1'b0;
    logic [31:0] cmd_ticks = '0;
    logic [4:0]  cmd_num = '0;
    logic [15:0] cmd_res = '0;
    logic        stall, irq_req;
    logic [4:0]  irq_num;

    int vectors = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cpu_wait_timer dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cancel(cmd_cancel),
        .cmd_ticks(cmd_ticks), .cmd_num(cmd_num), .cmd_res(cmd_res),
        .irq_ack(irq_ack), .stall(stall), .irq_req(irq_req), .irq_num(irq_num)
    );

    function automatic int exp_delay(int t, int r);
        int n = (r == 0) ? 1 : r;
        int d = t * n;
        return (d == 0) ? 1 : d;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // caller stands at a negedge; returns at the negedge of the first cycle after sampling
    task automatic issue(bit cancel, int t, int num, int r);
        cmd_valid = 1'b1; cmd_cancel = cancel;
        cmd_ticks = 32'(t); cmd_num = 5'(num); cmd_res = 16'(r);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_cancel = 1'b0;
    endtask

    task automatic count_stall(output int n, output bit irq_seen);
        n = 0; irq_seen = 0;
        while (stall && n < 5000) begin
            if (irq_req) irq_seen = 1;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_irq(output int c, output bit stalled);
        c = 1; stalled = 0;
        while (!irq_req && c < 5000) begin
            if (stall) stalled = 1;
            c++;
            @(negedge clk);
        end
    endtask

    task automatic ack_irq();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic run_wait(int t, int r, string req);
        int n; bit s;
        issue(0, t, 0, r);
        count_stall(n, s);
        check(n == exp_delay(t, r), req, n, exp_delay(t, r));
    endtask

    task automatic run_timer(int t, int num, int r, string req);
        int c; bit st;
        issue(0, t, num, r);
        count_irq(c, st);
        check(c == exp_delay(t, r) + 1, req, c, exp_delay(t, r) + 1);
        check(!st, {req, " stall"}, int'(st), 0);
        check(irq_num == 5'(num), {req, " num"}, int'(irq_num), num);
        ack_irq();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int n, c; bit s, st;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(stall == 0, "R1 stall", int'(stall), 0);
        check(irq_req == 0, "R1 irq_req", int'(irq_req), 0);
        check(irq_num == 0, "R1 irq_num", int'(irq_num), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 directed waits
        run_wait(1, 0, "R2");
        run_wait(7, 0, "R2");
        run_wait(4, 3, "R2");
        run_wait(1, 9, "R2");
        // R3 zero ticks
        run_wait(0, 0, "R3");
        run_wait(0, 6, "R3");
        run_timer(0, 3, 5, "R3");

        // R4 timers
        run_timer(5, 1, 0, "R4");
        run_timer(3, 31, 4, "R4");

        // R5 hold then ack
        issue(0, 2, 12, 0);
        count_irq(c, st);
        repeat (6) @(negedge clk);
        check(irq_req == 1, "R5 held", int'(irq_req), 1);
        ack_irq();
        check(irq_req == 0, "R5 cleared", int'(irq_req), 1'b0);
        // R5 expiry in ack cycle keeps request: timer D=1 fires in cycle 1 after sampling
        issue(0, 1, 4, 0);
        count_irq(c, st);
        issue(0, 1, 6, 0);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check(irq_req == 1, "R5 ack+fire", int'(irq_req), 1);
        check(irq_num == 6, "R5 ack+fire num", int'(irq_num), 6);
        ack_irq();

        // R6 cancel wait
        issue(0, 10, 0, 3);
        repeat (4) @(negedge clk);
        issue(1, 0, 0, 0);
        check(stall == 0, "R6", int'(stall), 0);
        repeat (40) @(negedge clk);
        check(stall == 0, "R6 stays", int'(stall), 0);

        // R7 cancel timer
        issue(0, 8, 5, 2);
        repeat (3) @(negedge clk);
        issue(1, 0, 5, 0);
        repeat (40) @(negedge clk);
        check(irq_req == 0, "R7", int'(irq_req), 0);

        // R8 restart
        issue(0, 50, 2, 0);
        repeat (9) @(negedge clk);
        issue(0, 3, 7, 0);
        count_irq(c, st);
        check(c == 4, "R8 timing", c, 4);
        check(irq_num == 7, "R8 num", int'(irq_num), 7);
        ack_irq();
        repeat (60) @(negedge clk);
        check(irq_req == 0, "R8 old never fires", int'(irq_req), 0);

        // R9 timer expiry mid-wait, acked during the wait
        issue(0, 5, 9, 0);
        issue(0, 30, 0, 0);
        n = 0; s = 0;
        while (stall && n < 5000) begin
            if (irq_req) begin s = 1; irq_ack = 1'b1; end
            else irq_ack = 1'b0;
            n++;
            @(negedge clk);
        end
        irq_ack = 1'b0;
        check(n == 30, "R9 wait length", n, 30);
        check(s == 1, "R9 irq during wait", int'(s), 1);
        check(irq_req == 0, "R9 acked", int'(irq_req), 0);

        // R9 simultaneous expiry
        issue(0, 21, 11, 0);
        issue(0, 20, 0, 0);
        count_stall(n, s);
        check(n == 20, "R9 same-cycle wait", n, 20);
        check(s == 0, "R9 no early irq", int'(s), 0);
        check(irq_req == 1, "R9 same-cycle irq", int'(irq_req), 1);
        check(irq_num == 11, "R9 same-cycle num", int'(irq_num), 11);
        ack_irq();

        // random mix
        for (int i = 0; i < 40; i++) begin
            int t = int'($urandom % 13);
            int r = int'($urandom % 5);
            if ($urandom % 2 == 0) run_wait(t, r, "R2 random");
            else run_timer(t, 1 + int'($urandom % 31), r, "R4 random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule